// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block merges four reset causes into the single internal reset of a small CPU core. The causes are an active-low external reset pin, a software strobe that writes a reset bit in the low-power control register, a watchdog overflow pulse and a low-voltage detect level. The pin first passes through a two-flop synchronizer. It then passes a width filter, so that only a low level that lasts long enough is taken as a request. The oscillator, the watchdog counter, the voltage comparator and the CPU are outside the block and reach it as plain strobes and levels.

Each source follows its own policy. A pin request is held pending until the CPU reports that an instruction, or one transfer of a string instruction, has completed, so that a write in progress finishes normally. If the CPU stays stalled on an external bus cycle for too long, the pending request is accepted anyway. A pin reset keeps the internal reset asserted for an oscillator-stabilization interval. The software, watchdog and low-voltage causes assert the reset at once and hold it only for the minimum width. A sticky cause register records every source that fired. Only a read-clear strobe or power-on clears it, so software can read it after the reset it records.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While and after power-on reset `rst`, `sys_rst` is 0 and `cause` is 4'b0000.
- R2: The pin is synchronized by two flops. A low level is accepted only if it lasts at least LOW_CYC = ceil(MIN_LOW_NS / CLK_NS) clocks. Shorter lows cause no reset and set no cause bit.
- R3: An accepted pin request does not assert `sys_rst` until `insn_done` is high, while no other cause is active.
- R4: A pin reset that is accepted after the pin has returned high holds `sys_rst` for exactly STAB_CYC cycles.
- R5: While a pin request is pending, `bus_wait` held high for FORCE_CYC consecutive clock edges asserts `sys_rst` after the FORCE_CYC-th edge. Dropping `bus_wait` earlier restarts the count.
- R6: A cycle with `sw_wr`=1 and `sw_val`=0 asserts `sys_rst` on the next cycle for MIN_RST cycles. A write with `sw_val`=1 is ignored.
- R7: A `wdt_ovf` pulse asserts `sys_rst` on the next cycle for MIN_RST cycles, with no stabilization wait.
- R8: `lvd` high asserts `sys_rst` without a stabilization wait. A level high for L cycles gives a reset L+MIN_RST-1 cycles wide.
- R9: `cause` bit 0 = pin, bit 1 = software, bit 2 = watchdog, bit 3 = low voltage. The bits are sticky. They are set when the cause is detected, are not cleared by `sys_rst`, and are cleared by `cause_clr`. A new set wins over a clear in the same cycle.
- R10: Causes that arrive together all set their bits. If a pin request is among them, the stabilization width STAB_CYC applies.
- R11: `sys_rst` is a registered output and every pulse lasts at least MIN_RST cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sw_wr | input | 1 | Write strobe for the software reset bit |
| sw_val | input | 1 | Value written; 0 requests a reset |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| lvd | input | 1 | Low-voltage detect level |
| insn_done | input | 1 | CPU instruction or single-transfer completion |
| bus_wait | input | 1 | CPU stalled in an external bus cycle |
| cause_clr | input | 1 | Read-clear strobe for the cause register |
| sys_rst | output | 1 | Internal reset, active high, registered |
| cause | output | 4 | Sticky reset-cause bits |

## Verification
The assertions run on every cycle. They check that no reset pulse is shorter than the minimum width and that a software reset request raises the reset on the next cycle. They also check that a stalled pending pin request never outlasts the force window, and that cause bits never drop without a clear. The bench scenarios are needed for behaviour that depends on history. This covers the exact width of each pulse for each mix of causes, the rejection of short pin glitches, the hold-off until instruction completion, the restart of the stall count, and the cause bits surviving the reset they record.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PEND = 2'd1,
    SEQ_ACT  = 2'd2
  } seq_state_t;

  localparam int SRC_N   = 4;
  localparam int SRC_PIN = 0;
  localparam int SRC_SW  = 1;
  localparam int SRC_WDT = 2;
  localparam int SRC_LVD = 3;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int LOW_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic pin_low_o,
  output logic pin_evt_o
);
  localparam int CW = $clog2(LOW_CYC + 1);

  logic          sync1, sync2;
  logic [CW-1:0] run;
  logic          low_q, low_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      run   <= '0;
      low_q <= 1'b0;
      low_d <= 1'b0;
    end else begin
      sync1 <= pin_n_i;
      sync2 <= sync1;
      if (sync2)
        run <= '0;
      else if (run != CW'(LOW_CYC))
        run <= run + 1'b1;
      low_q <= !sync2 && (run >= CW'(LOW_CYC - 1));
      low_d <= low_q;
    end
  end

  assign pin_low_o = low_q;
  assign pin_evt_o = low_q && !low_d;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (clr_i ? '0 : q) | set_i;
  end

  assign cause_o = q;

  // R9
  sticky_bits_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_i) |-> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int MIN_RST   = 4,
  parameter int STAB_CYC  = 1024,
  parameter int FORCE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_evt_i,
  input  logic pin_low_i,
  input  logic sw_evt_i,
  input  logic wdt_evt_i,
  input  logic lvd_i,
  input  logic insn_done_i,
  input  logic bus_wait_i,
  output logic sys_rst_o
);
  localparam int CW = $clog2(STAB_CYC + 1);
  localparam int SW = $clog2(FORCE_CYC + 2);

  seq_state_t    st, st_n;
  logic [CW-1:0] cnt, cnt_n, target;
  logic [SW-1:0] stall, stall_n;
  logic          stab, stab_n;
  logic          now_evt, force_hit, hold;

  assign now_evt   = sw_evt_i || wdt_evt_i || lvd_i;
  assign hold      = lvd_i || pin_low_i;
  assign force_hit = bus_wait_i && (stall == SW'(FORCE_CYC - 1));
  assign target    = stab ? CW'(STAB_CYC - 1) : CW'(MIN_RST - 1);

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    stall_n = stall;
    stab_n  = stab;
    case (st)
      SEQ_IDLE: begin
        if (now_evt) begin
          st_n   = SEQ_ACT;
          cnt_n  = '0;
          stab_n = pin_evt_i;
        end else if (pin_evt_i) begin
          st_n    = SEQ_PEND;
          stall_n = '0;
        end
      end
      SEQ_PEND: begin
        stall_n = bus_wait_i ? stall + 1'b1 : '0;
        if (now_evt || insn_done_i || force_hit) begin
          st_n   = SEQ_ACT;
          cnt_n  = '0;
          stab_n = 1'b1;
        end
      end
      SEQ_ACT: begin
        if (sw_evt_i || wdt_evt_i || pin_evt_i || hold) begin
          cnt_n  = '0;
          stab_n = stab || pin_evt_i;
        end else if (cnt == target) begin
          st_n   = SEQ_IDLE;
          stab_n = 1'b0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SEQ_IDLE;
      cnt       <= '0;
      stall     <= '0;
      stab      <= 1'b0;
      sys_rst_o <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      stall     <= stall_n;
      stab      <= stab_n;
      sys_rst_o <= (st_n == SEQ_ACT);
    end
  end

  logic [SW-1:0] chk_stall;
  always_ff @(posedge clk) begin
    if (rst) chk_stall <= '0;
    else if (st == SEQ_PEND && bus_wait_i) chk_stall <= chk_stall + 1'b1;
    else chk_stall <= '0;
  end

  // R5
  force_bound_chk: assert property (@(posedge clk) disable iff (rst)
    chk_stall <= SW'(FORCE_CYC));

  // R6
  sw_prompt_chk: assert property (@(posedge clk) disable iff (rst)
    sw_evt_i |=> sys_rst_o);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int CLK_NS     = 20,
  parameter int MIN_LOW_NS = 500,
  parameter int MIN_RST    = 4,
  parameter int STAB_CYC   = 1024,
  parameter int FORCE_CYC  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_rst_n,
  input  logic       sw_wr,
  input  logic       sw_val,
  input  logic       wdt_ovf,
  input  logic       lvd,
  input  logic       insn_done,
  input  logic       bus_wait,
  input  logic       cause_clr,
  output logic       sys_rst,
  output logic [3:0] cause
);
  localparam int LOW_CYC = (MIN_LOW_NS + CLK_NS - 1) / CLK_NS;

  logic pin_low, pin_evt, sw_evt;
  logic [SRC_N-1:0] set_vec;

  assign sw_evt = sw_wr && !sw_val;

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_PIN] = pin_evt;
    set_vec[SRC_SW]  = sw_evt;
    set_vec[SRC_WDT] = wdt_ovf;
    set_vec[SRC_LVD] = lvd;
  end

  rst_pin_filter #(.LOW_CYC(LOW_CYC)) u_filt (
    .clk(clk), .rst(rst), .pin_n_i(ext_rst_n),
    .pin_low_o(pin_low), .pin_evt_o(pin_evt)
  );

  rst_seq_fsm #(.MIN_RST(MIN_RST), .STAB_CYC(STAB_CYC), .FORCE_CYC(FORCE_CYC)) u_fsm (
    .clk(clk), .rst(rst), .pin_evt_i(pin_evt), .pin_low_i(pin_low),
    .sw_evt_i(sw_evt), .wdt_evt_i(wdt_ovf), .lvd_i(lvd),
    .insn_done_i(insn_done), .bus_wait_i(bus_wait), .sys_rst_o(sys_rst)
  );

  rst_cause_reg #(.N(SRC_N)) u_cause (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(cause_clr), .cause_o(cause)
  );

  logic [15:0] chk_hi;
  always_ff @(posedge clk) begin
    if (rst) chk_hi <= '0;
    else if (sys_rst) chk_hi <= (chk_hi == 16'hFFFF) ? chk_hi : chk_hi + 1'b1;
    else chk_hi <= '0;
  end

  // R11
  min_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> (chk_hi >= 16'(MIN_RST)));
endmodule

// File: tb/tb_rst_seq_ctrl.sv
`timescale 1ns/1ps
module tb_rst_seq_ctrl;
  localparam int CLK_PERIOD = 100;
  localparam int MIN_LOW_NS = 500;
  localparam int LOW_CYC    = 5;
  localparam int MIN_RST    = 4;
  localparam int STAB_CYC   = 20;
  localparam int FORCE_CYC  = 16;

  logic clk = 0, rst = 1;
  logic ext_rst_n = 1, sw_wr = 0, sw_val = 1, wdt_ovf = 0, lvd = 0;
  logic insn_done = 0, bus_wait = 0, cause_clr = 0;
  logic sys_rst;
  logic [3:0] cause;

  int n_run = 0, n_fail = 0;

  typedef struct packed { int w; logic [3:0] c; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_seq_ctrl #(.CLK_NS(CLK_PERIOD), .MIN_LOW_NS(MIN_LOW_NS), .MIN_RST(MIN_RST),
                 .STAB_CYC(STAB_CYC), .FORCE_CYC(FORCE_CYC)) dut (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .sw_wr(sw_wr), .sw_val(sw_val),
    .wdt_ovf(wdt_ovf), .lvd(lvd), .insn_done(insn_done), .bus_wait(bus_wait),
    .cause_clr(cause_clr), .sys_rst(sys_rst), .cause(cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the expected pulse at each falling edge of sys_rst
  logic prev_rst = 0;
  int   width = 0;
  always @(negedge clk) begin
    if (sys_rst) width++;
    if (prev_rst && !sys_rst) begin
      if (q.size() == 0) begin
        check(0, "R11 unexpected reset pulse", width, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(width == e.w, "R4/R6/R7/R8/R10 pulse width", width, e.w);
        check(cause == e.c, "R9/R10 cause after reset", cause, e.c);
      end
      width = 0;
    end
    prev_rst = sys_rst;
  end

  task automatic wait_done;
    for (int i = 0; i < 500 && (q.size() != 0 || sys_rst); i++) tick(1);
    tick(3);
  endtask

  task automatic clear_causes;
    cause_clr = 1; tick(1); cause_clr = 0; tick(1);
    check(cause == 4'b0000, "R9 cleared by cause_clr", cause, 0);
  endtask

  task automatic pin_low(input int n);
    ext_rst_n = 0; tick(n); ext_rst_n = 1; tick(6);
  endtask

  task automatic sw_write(input logic v);
    sw_wr = 1; sw_val = v; tick(1); sw_wr = 0; sw_val = 1;
  endtask

  initial begin
    tick(4);
    check(sys_rst == 0, "R1 reset sys_rst", sys_rst, 0);
    check(cause == 0, "R1 reset cause", cause, 0);
    rst = 0; tick(3);
    check(sys_rst == 0 && cause == 0, "R1 after release", {cause, sys_rst}, 0);

    // R2: short glitch ignored
    pin_low(LOW_CYC - 2); tick(10);
    check(sys_rst == 0, "R2 short low no reset", sys_rst, 0);
    check(cause == 0, "R2 short low no cause", cause, 0);

    // R3/R4: accepted pin waits for insn_done, then stab width
    pin_low(LOW_CYC + 5); tick(10);
    check(sys_rst == 0, "R3 pending pin holds off", sys_rst, 0);
    check(cause == 4'b0001, "R9 pin bit on detect", cause, 1);
    q.push_back('{STAB_CYC, 4'b0001});
    insn_done = 1; tick(1); insn_done = 0;
    wait_done(); clear_causes();

    // R6: write of 1 ignored, write of 0 resets
    sw_write(1); tick(10);
    check(sys_rst == 0 && cause == 0, "R6 write 1 ignored", {cause, sys_rst}, 0);
    q.push_back('{MIN_RST, 4'b0010});
    sw_write(0); wait_done(); clear_causes();

    // R7: watchdog
    q.push_back('{MIN_RST, 4'b0100});
    wdt_ovf = 1; tick(1); wdt_ovf = 0;
    wait_done(); clear_causes();

    // R8: low voltage level for 7 cycles
    q.push_back('{7 + MIN_RST - 1, 4'b1000});
    lvd = 1; tick(7); lvd = 0;
    wait_done(); clear_causes();

    // R10: software and watchdog together
    q.push_back('{MIN_RST, 4'b0110});
    sw_wr = 1; sw_val = 0; wdt_ovf = 1; tick(1);
    sw_wr = 0; sw_val = 1; wdt_ovf = 0;
    wait_done(); clear_causes();

    // R10: pending pin joined by software request -> stabilization width
    pin_low(LOW_CYC + 5); tick(4);
    check(sys_rst == 0, "R3 pending before software", sys_rst, 0);
    q.push_back('{STAB_CYC, 4'b0011});
    sw_write(0); wait_done(); clear_causes();

    // R5: broken stall does not force, full stall does
    pin_low(LOW_CYC + 5); tick(2);
    bus_wait = 1; tick(5); bus_wait = 0; tick(20);
    check(sys_rst == 0, "R5 broken stall no force", sys_rst, 0);
    q.push_back('{STAB_CYC, 4'b0001});
    bus_wait = 1; tick(FORCE_CYC - 1);
    check(sys_rst == 0, "R5 not before window end", sys_rst, 0);
    tick(1);
    check(sys_rst == 1, "R5 forced at window end", sys_rst, 1);
    bus_wait = 0;
    wait_done(); clear_causes();

    check(q.size() == 0, "R11 all expected pulses seen", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog timeout (R1..R11 run incomplete) actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule